// File: doc/BRIEF.md
# Control Endpoint Zero Transaction Engine

This block runs the device side of control transfers on endpoint zero. It works at the token and handshake level. A packet front end hands it decoded token events: SETUP, IN and OUT. For SETUP and OUT tokens the front end then streams the data bytes and marks the end of the packet, together with the packet's data toggle. The host's handshake on a packet the device sent arrives as a single pulse. For each token the engine decides the device's reply: ACK, NAK, or a data packet with a given toggle and length. The front end reads the bytes of a data packet out of the endpoint buffer one by one.

Firmware decodes the request and owns the buffer between packets. It sees four status flags: setup received, transmit ready, transmit done and receive data. It also sees a byte count and three one-cycle event strobes. Firmware has a byte port into the buffer and single-cycle pulses that set or clear its flags. Each status stage waits on these flags. The engine keeps sending NAK, or keeps offering a zero-length DATA1 packet, until firmware or the host moves the transfer on.

Top module: `ctl_ep0_engine`

## Requirements
- R1: A SETUP token followed by its data bytes is answered with ACK. The bytes are stored in the buffer from index 0. The byte count takes the number of bytes received, the setup flag is set, and the setup strobe pulses for one cycle.
- R2: While the endpoint enable input is low, no token gets any reply and no flag changes.
- R3: While the setup flag is set, every IN token and every OUT packet is answered with NAK.
- R4: After a SETUP with direction 0 and no OUT data, each IN token gets a zero-length DATA1 packet until the host handshake arrives. The handshake then sets the transmit-done flag and pulses its strobe, and later IN tokens get NAK.
- R5: In a host-to-device transfer (direction 0), an OUT packet carrying the expected toggle is ACKed, and its bytes replace the buffer from index 0. It sets the receive-data flag and the byte count, and the expected toggle alternates. While that flag is set, further OUT packets are NAKed.
- R6: An OUT data packet with the wrong toggle is ACKed but discarded. The receive-data flag stays clear and the byte count keeps its value.
- R7: After OUT data in a direction-0 transfer, IN tokens get a zero-length DATA1 packet, repeated until the host handshake. The handshake sets transmit-done.
- R8: In a device-to-host transfer (direction 1), an IN token gets NAK while transmit-ready is clear. While it is set, the IN token gets a data packet: its length is the byte count, its bytes come from buffer index 0 upward, and its toggle starts at DATA1 after SETUP. Without a handshake the same packet is sent again. The handshake clears transmit-ready, sets transmit-done and flips the toggle.
- R9: In a direction-1 transfer, a status OUT packet is NAKed while transmit-done is set. After firmware clears transmit-done, the retried OUT is ACKed and the transfer ends.
- R10: Firmware writes to the buffer and to the byte count have no effect while transmit-ready is set.
- R11: A SETUP overrides any stage in progress. It clears transmit-ready, transmit-done and receive-data, and sets the expected toggle back to DATA1.
- R12: A reply appears for exactly one cycle. For an IN it comes in the cycle after the token; for SETUP and OUT it comes in the cycle after the packet end. Token codes are OUT=1, IN=2, SETUP=3. Reply codes are ACK=1, NAK=2, DATA=3.
- R13: After reset all flags are clear, the byte count is zero and there is no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_en | input | 1 | Endpoint enable |
| ep_dir | input | 1 | Transfer direction, 1 = device to host |
| tok_vld | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token code |
| rx_wr | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_end | input | 1 | End of received data packet |
| rx_tgl | input | 1 | Toggle of received data packet |
| hs_ack | input | 1 | Host handshake on the sent packet |
| tx_rd | input | 1 | Advance to next transmit byte |
| tx_byte | output | 8 | Current transmit byte |
| rsp_vld | output | 1 | Reply strobe |
| rsp_kind | output | 2 | Reply code |
| rsp_tgl | output | 1 | Toggle of data reply |
| rsp_len | output | CW | Length of data reply |
| fw_addr | input | AW | Firmware buffer index |
| fw_we | input | 1 | Firmware buffer write |
| fw_wdata | input | 8 | Firmware write byte |
| fw_rdata | output | 8 | Buffer byte at fw_addr |
| fw_cnt_we | input | 1 | Firmware byte-count write |
| fw_cnt | input | CW | Byte count to write |
| fw_set_txrdy | input | 1 | Set transmit-ready |
| fw_clr_setup | input | 1 | Clear setup flag |
| fw_clr_txdone | input | 1 | Clear transmit-done |
| fw_clr_rxdata | input | 1 | Clear receive-data |
| st_setup | output | 1 | Setup received flag |
| st_txrdy | output | 1 | Transmit-ready flag |
| st_txdone | output | 1 | Transmit-done flag |
| st_rxdata | output | 1 | Receive-data flag |
| byte_cnt | output | CW | Byte count |
| ev_setup | output | 1 | Setup accepted strobe |
| ev_txdone | output | 1 | Transmit-done strobe |
| ev_rxdata | output | 1 | Receive-data strobe |

## Verification
The bench builds the engine with an eight-byte buffer, the smallest size that holds a setup packet. That size makes every packet length from empty to a full buffer reachable in both directions. Each length is swept through a full host-to-device transfer and a full device-to-host transfer. Each sweep includes toggle errors, retries without a handshake, firmware writes attempted while transmit-ready is set, and status stages held off by the flags. Expected bytes come from a simple arithmetic pattern of seed and index.

// File: rtl/ep0_pkg.sv
// Shared codes for the endpoint-zero engine.
// Assumes two-bit token and reply codes as listed in the brief.
package ep0_pkg;
    typedef enum logic [1:0] {TK_NONE = 2'd0, TK_OUT = 2'd1, TK_IN = 2'd2, TK_SETUP = 2'd3} tok_e;
    typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_ACK = 2'd1, RSP_NAK = 2'd2, RSP_DATA = 2'd3} rsp_e;
    typedef enum logic {PH_IDLE = 1'b0, PH_CTRL = 1'b1} phase_e;
    typedef enum logic [1:0] {AW_NONE = 2'd0, AW_DATA = 2'd1, AW_STATUS = 2'd2} await_e;
endpackage

// File: rtl/ep0_buf.sv
// Endpoint byte buffer with a packet-side pointer and a firmware-side index port.
// Packet writes and transmit reads share one pointer, which restarts at each token.
// Assumes DEPTH is at least 1. The pointer stops at DEPTH; bytes past the end are dropped.
module ep0_buf #(
    parameter int DEPTH = 8,
    parameter int AW = 3,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pk_rst,
    input  logic          pk_we,
    input  logic [7:0]    pk_wdata,
    input  logic          pk_rd,
    output logic [CW-1:0] pk_cnt,
    output logic [7:0]    pk_rdata,
    input  logic          fw_we,
    input  logic [AW-1:0] fw_addr,
    input  logic [7:0]    fw_wdata,
    output logic [7:0]    fw_rdata
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] ptr;
    logic          in_range;

    // Pointer is inside the buffer
    assign in_range = (ptr < CW'(DEPTH));

    // Packet pointer: restart on token, advance on each byte written or read
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (pk_rst)
            ptr <= '0;
        else if ((pk_we || pk_rd) && in_range)
            ptr <= ptr + 1'b1;
    end

    // Storage write: the packet side wins over the firmware side
    always_ff @(posedge clk) begin
        if (pk_we && in_range)
            mem[ptr[AW-1:0]] <= pk_wdata;
        else if (fw_we)
            mem[fw_addr] <= fw_wdata;
    end

    assign pk_cnt   = ptr;
    assign pk_rdata = in_range ? mem[ptr[AW-1:0]] : 8'h00;
    assign fw_rdata = mem[fw_addr];
endmodule

// File: rtl/ep0_seq.sv
// Transaction sequencer for control endpoint zero.
// Decides the reply to each token, tracks the stage and data toggle, and keeps
// the firmware flags. Hardware events take priority over firmware pulses in the
// same cycle. Assumes at most one of tok_vld, rx_end and hs_ack per cycle.
module ep0_seq
    import ep0_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ep_en,
    input  logic          ep_dir,
    input  logic          tok_vld,
    input  logic [1:0]    tok_kind,
    input  logic          rx_end,
    input  logic          rx_tgl,
    input  logic [CW-1:0] pk_cnt,
    input  logic          hs_ack,
    input  logic          fw_set_txrdy,
    input  logic          fw_clr_setup,
    input  logic          fw_clr_txdone,
    input  logic          fw_clr_rxdata,
    input  logic          fw_cnt_we,
    input  logic [CW-1:0] fw_cnt,
    output logic          wr_ok,
    output logic          rsp_vld,
    output logic [1:0]    rsp_kind,
    output logic          rsp_tgl,
    output logic [CW-1:0] rsp_len,
    output logic          st_setup,
    output logic          st_txrdy,
    output logic          st_txdone,
    output logic          st_rxdata,
    output logic [CW-1:0] byte_cnt,
    output logic          ev_setup,
    output logic          ev_txdone,
    output logic          ev_rxdata
);
    phase_e phase_q;
    await_e aw_q;
    tok_e   cur_q;
    tok_e   kind_in;
    rsp_e   rsp_q;
    logic   tgl_q;
    logic   open_q;
    logic   tok_go;
    logic   end_go;

    // Decode the incoming events
    always_comb begin
        kind_in = tok_e'(tok_kind);
        tok_go  = tok_vld && ep_en;
        end_go  = rx_end && ep_en && (cur_q != TK_NONE);
        open_q  = (phase_q == PH_CTRL) && !st_setup;
    end

    // Stage, toggle, flags and reply register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            aw_q      <= AW_NONE;
            cur_q     <= TK_NONE;
            tgl_q     <= 1'b1;
            wr_ok     <= 1'b0;
            rsp_vld   <= 1'b0;
            rsp_q     <= RSP_NONE;
            rsp_tgl   <= 1'b0;
            rsp_len   <= '0;
            st_setup  <= 1'b0;
            st_txrdy  <= 1'b0;
            st_txdone <= 1'b0;
            st_rxdata <= 1'b0;
            byte_cnt  <= '0;
            ev_setup  <= 1'b0;
            ev_txdone <= 1'b0;
            ev_rxdata <= 1'b0;
        end else begin
            rsp_vld   <= 1'b0;
            ev_setup  <= 1'b0;
            ev_txdone <= 1'b0;
            ev_rxdata <= 1'b0;
            // firmware actions first, so hardware events below override them
            if (fw_clr_setup)  st_setup  <= 1'b0;
            if (fw_clr_txdone) st_txdone <= 1'b0;
            if (fw_clr_rxdata) st_rxdata <= 1'b0;
            if (fw_set_txrdy)  st_txrdy  <= 1'b1;
            if (fw_cnt_we && !st_txrdy) byte_cnt <= fw_cnt;
            // host handshake on the packet the engine sent
            if (hs_ack) begin
                if (aw_q == AW_DATA) begin
                    st_txrdy  <= 1'b0;
                    st_txdone <= 1'b1;
                    ev_txdone <= 1'b1;
                    tgl_q     <= ~tgl_q;
                end else if (aw_q == AW_STATUS) begin
                    st_txdone <= 1'b1;
                    ev_txdone <= 1'b1;
                    phase_q   <= PH_IDLE;
                end
                aw_q <= AW_NONE;
            end
            // token: IN replies now, SETUP and OUT wait for the packet end
            if (tok_go) begin
                aw_q  <= AW_NONE;
                cur_q <= (kind_in == TK_IN) ? TK_NONE : kind_in;
                wr_ok <= (kind_in == TK_SETUP) ||
                         ((kind_in == TK_OUT) && open_q && !ep_dir && !st_rxdata);
                if (kind_in == TK_IN) begin
                    rsp_vld <= 1'b1;
                    rsp_tgl <= 1'b0;
                    rsp_len <= '0;
                    rsp_q   <= RSP_NAK;
                    if (open_q && !ep_dir) begin
                        rsp_q   <= RSP_DATA;
                        rsp_tgl <= 1'b1;
                        aw_q    <= AW_STATUS;
                    end else if (open_q && st_txrdy) begin
                        rsp_q   <= RSP_DATA;
                        rsp_tgl <= tgl_q;
                        rsp_len <= byte_cnt;
                        aw_q    <= AW_DATA;
                    end
                end
            end
            // end of a received data packet
            if (end_go) begin
                rsp_vld <= 1'b1;
                rsp_tgl <= 1'b0;
                rsp_len <= '0;
                cur_q   <= TK_NONE;
                wr_ok   <= 1'b0;
                rsp_q   <= RSP_NAK;
                if (cur_q == TK_SETUP) begin
                    rsp_q     <= RSP_ACK;
                    st_setup  <= 1'b1;
                    ev_setup  <= 1'b1;
                    byte_cnt  <= pk_cnt;
                    phase_q   <= PH_CTRL;
                    tgl_q     <= 1'b1;
                    st_txrdy  <= 1'b0;
                    st_txdone <= 1'b0;
                    st_rxdata <= 1'b0;
                    aw_q      <= AW_NONE;
                end else if (open_q && ep_dir) begin
                    if (!st_txdone) begin
                        rsp_q   <= RSP_ACK;
                        phase_q <= PH_IDLE;
                    end
                end else if (open_q && !st_rxdata) begin
                    rsp_q <= RSP_ACK;
                    if (rx_tgl == tgl_q) begin
                        st_rxdata <= 1'b1;
                        ev_rxdata <= 1'b1;
                        byte_cnt  <= pk_cnt;
                        tgl_q     <= ~tgl_q;
                    end
                end
            end
        end
    end

    assign rsp_kind = rsp_q;
endmodule

// File: rtl/ctl_ep0_engine.sv
// Control endpoint zero engine: a sequencer joined to the endpoint buffer.
// Buffer writes from the packet side only take place while the sequencer
// accepts the packet. Firmware writes only take place while transmit-ready is clear.
module ctl_ep0_engine #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ep_en,
    input  logic          ep_dir,
    input  logic          tok_vld,
    input  logic [1:0]    tok_kind,
    input  logic          rx_wr,
    input  logic [7:0]    rx_byte,
    input  logic          rx_end,
    input  logic          rx_tgl,
    input  logic          hs_ack,
    input  logic          tx_rd,
    output logic [7:0]    tx_byte,
    output logic          rsp_vld,
    output logic [1:0]    rsp_kind,
    output logic          rsp_tgl,
    output logic [CW-1:0] rsp_len,
    input  logic [AW-1:0] fw_addr,
    input  logic          fw_we,
    input  logic [7:0]    fw_wdata,
    output logic [7:0]    fw_rdata,
    input  logic          fw_cnt_we,
    input  logic [CW-1:0] fw_cnt,
    input  logic          fw_set_txrdy,
    input  logic          fw_clr_setup,
    input  logic          fw_clr_txdone,
    input  logic          fw_clr_rxdata,
    output logic          st_setup,
    output logic          st_txrdy,
    output logic          st_txdone,
    output logic          st_rxdata,
    output logic [CW-1:0] byte_cnt,
    output logic          ev_setup,
    output logic          ev_txdone,
    output logic          ev_rxdata
);
    logic          wr_ok;
    logic [CW-1:0] pk_cnt;

    ep0_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ep_en(ep_en), .ep_dir(ep_dir),
        .tok_vld(tok_vld), .tok_kind(tok_kind), .rx_end(rx_end), .rx_tgl(rx_tgl),
        .pk_cnt(pk_cnt), .hs_ack(hs_ack),
        .fw_set_txrdy(fw_set_txrdy), .fw_clr_setup(fw_clr_setup),
        .fw_clr_txdone(fw_clr_txdone), .fw_clr_rxdata(fw_clr_rxdata),
        .fw_cnt_we(fw_cnt_we), .fw_cnt(fw_cnt), .wr_ok(wr_ok),
        .rsp_vld(rsp_vld), .rsp_kind(rsp_kind), .rsp_tgl(rsp_tgl), .rsp_len(rsp_len),
        .st_setup(st_setup), .st_txrdy(st_txrdy), .st_txdone(st_txdone),
        .st_rxdata(st_rxdata), .byte_cnt(byte_cnt),
        .ev_setup(ev_setup), .ev_txdone(ev_txdone), .ev_rxdata(ev_rxdata)
    );

    ep0_buf #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .pk_rst(tok_vld && ep_en),
        .pk_we(rx_wr && wr_ok), .pk_wdata(rx_byte),
        .pk_rd(tx_rd), .pk_cnt(pk_cnt), .pk_rdata(tx_byte),
        .fw_we(fw_we && !st_txrdy), .fw_addr(fw_addr),
        .fw_wdata(fw_wdata), .fw_rdata(fw_rdata)
    );
endmodule

// File: rtl/ep0_engine_chk.sv
// Protocol checker for the endpoint-zero engine, attached to the top by bind.
// Watches only the top-level ports.
module ep0_engine_chk
    import ep0_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ep_en,
    input logic       ep_dir,
    input logic       tok_vld,
    input logic       rx_end,
    input logic       hs_ack,
    input logic       rsp_vld,
    input logic [1:0] rsp_kind,
    input logic       st_setup,
    input logic       st_txrdy,
    input logic       st_txdone,
    input logic       st_rxdata,
    input logic       ev_setup,
    input logic       ev_rxdata
);
    p_off_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(ep_en));

    p_setup_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |-> (rsp_vld && rsp_kind == RSP_ACK && st_setup));

    p_txrdy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_txrdy) |-> ($past(hs_ack) || ev_setup));

    p_status_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_kind == RSP_ACK && !ev_setup && $past(ep_dir)) |-> !$past(st_txdone));

    p_rxdata_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_rxdata) |-> (rsp_vld && rsp_kind == RSP_ACK && ev_rxdata));

    p_rsp_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(tok_vld || rx_end));
endmodule

bind ctl_ep0_engine ep0_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ep_en(ep_en), .ep_dir(ep_dir),
    .tok_vld(tok_vld), .rx_end(rx_end), .hs_ack(hs_ack),
    .rsp_vld(rsp_vld), .rsp_kind(rsp_kind),
    .st_setup(st_setup), .st_txrdy(st_txrdy), .st_txdone(st_txdone),
    .st_rxdata(st_rxdata), .ev_setup(ev_setup), .ev_rxdata(ev_rxdata)
);

// File: tb/ctl_ep0_engine_test.sv
// Self-checking bench: sweeps every packet length through both transfer directions.
module ctl_ep0_engine_test;
    localparam int DEPTH = 8;
    localparam int AW = 3;
    localparam int CW = 4;
    localparam int K_OUT = 1, K_IN = 2, K_SETUP = 3;
    localparam int R_NONE = 0, R_ACK = 1, R_NAK = 2, R_DATA = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ep_en = 1'b0, ep_dir = 1'b0;
    logic tok_vld = 1'b0, rx_wr = 1'b0, rx_end = 1'b0, rx_tgl = 1'b0;
    logic hs_ack = 1'b0, tx_rd = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic [7:0] rx_byte = 8'd0, fw_wdata = 8'd0;
    logic [AW-1:0] fw_addr = '0;
    logic fw_we = 1'b0, fw_cnt_we = 1'b0;
    logic [CW-1:0] fw_cnt = '0;
    logic fw_set_txrdy = 1'b0, fw_clr_setup = 1'b0, fw_clr_txdone = 1'b0, fw_clr_rxdata = 1'b0;
    logic [7:0] tx_byte, fw_rdata;
    logic rsp_vld, rsp_tgl;
    logic [1:0] rsp_kind;
    logic [CW-1:0] rsp_len, byte_cnt;
    logic st_setup, st_txrdy, st_txdone, st_rxdata, ev_setup, ev_txdone, ev_rxdata;

    int total = 0, bad = 0;
    int rk, rt, rl;
    logic cap_evs, cap_evr, cap_evt;

    ctl_ep0_engine #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .ep_en(ep_en), .ep_dir(ep_dir),
        .tok_vld(tok_vld), .tok_kind(tok_kind), .rx_wr(rx_wr), .rx_byte(rx_byte),
        .rx_end(rx_end), .rx_tgl(rx_tgl), .hs_ack(hs_ack), .tx_rd(tx_rd), .tx_byte(tx_byte),
        .rsp_vld(rsp_vld), .rsp_kind(rsp_kind), .rsp_tgl(rsp_tgl), .rsp_len(rsp_len),
        .fw_addr(fw_addr), .fw_we(fw_we), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
        .fw_cnt_we(fw_cnt_we), .fw_cnt(fw_cnt), .fw_set_txrdy(fw_set_txrdy),
        .fw_clr_setup(fw_clr_setup), .fw_clr_txdone(fw_clr_txdone), .fw_clr_rxdata(fw_clr_rxdata),
        .st_setup(st_setup), .st_txrdy(st_txrdy), .st_txdone(st_txdone), .st_rxdata(st_rxdata),
        .byte_cnt(byte_cnt), .ev_setup(ev_setup), .ev_txdone(ev_txdone), .ev_rxdata(ev_rxdata)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 5 + 3) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic grab();
        rk = rsp_vld ? int'(rsp_kind) : R_NONE;
        rt = int'(rsp_tgl);
        rl = int'(rsp_len);
        cap_evs = ev_setup; cap_evr = ev_rxdata; cap_evt = ev_txdone;
    endtask

    task automatic send_in();
        @(negedge clk); tok_vld = 1'b1; tok_kind = 2'(K_IN);
        @(negedge clk); tok_vld = 1'b0;
        grab();
    endtask

    task automatic send_pkt(input int kind, input int n, input int seed, input logic tgl);
        @(negedge clk); tok_vld = 1'b1; tok_kind = 2'(kind);
        @(negedge clk); tok_vld = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_wr = 1'b1; rx_byte = pat(seed, i);
            @(negedge clk);
        end
        rx_wr = 1'b0; rx_end = 1'b1; rx_tgl = tgl;
        @(negedge clk); rx_end = 1'b0;
        grab();
    endtask

    task automatic host_ack();
        @(negedge clk); hs_ack = 1'b1;
        @(negedge clk); hs_ack = 1'b0;
        cap_evt = ev_txdone;
    endtask

    task automatic fw_pulse(input int which);
        @(negedge clk);
        case (which)
            0: fw_clr_setup = 1'b1;
            1: fw_clr_txdone = 1'b1;
            2: fw_clr_rxdata = 1'b1;
            default: fw_set_txrdy = 1'b1;
        endcase
        @(negedge clk);
        fw_clr_setup = 1'b0; fw_clr_txdone = 1'b0; fw_clr_rxdata = 1'b0; fw_set_txrdy = 1'b0;
    endtask

    task automatic fw_write(input int a, input logic [7:0] d);
        @(negedge clk); fw_we = 1'b1; fw_addr = AW'(a); fw_wdata = d;
        @(negedge clk); fw_we = 1'b0;
    endtask

    task automatic fw_count(input int n);
        @(negedge clk); fw_cnt_we = 1'b1; fw_cnt = CW'(n);
        @(negedge clk); fw_cnt_we = 1'b0;
    endtask

    task automatic fw_peek(input string req, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            fw_addr = AW'(i); #1;
            chk(req, int'(fw_rdata), int'(pat(seed, i)));
        end
    endtask

    task automatic start_ctl(input logic dir);
        ep_dir = dir;
        send_pkt(K_SETUP, 8, 7, 1'b0);
        fw_pulse(0);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 setup", int'(st_setup), 0);
        chk("R13 txrdy", int'(st_txrdy), 0);
        chk("R13 txdone", int'(st_txdone), 0);
        chk("R13 rxdata", int'(st_rxdata), 0);
        chk("R13 count", int'(byte_cnt), 0);
        chk("R13 rsp", int'(rsp_vld), 0);
        rst_n = 1'b1;

        // R2 disabled endpoint stays silent
        send_pkt(K_SETUP, 8, 1, 1'b0);
        chk("R2 setup reply", rk, R_NONE);
        chk("R2 setup flag", int'(st_setup), 0);
        send_in();
        chk("R2 in reply", rk, R_NONE);
        ep_en = 1'b1;

        // R3 tokens before any setup are refused
        send_in();
        chk("R3 idle in", rk, R_NAK);

        // R1 setup capture
        ep_dir = 1'b0;
        send_pkt(K_SETUP, 8, 1, 1'b0);
        chk("R1 reply", rk, R_ACK);
        chk("R1 strobe", int'(cap_evs), 1);
        chk("R1 flag", int'(st_setup), 1);
        chk("R1 count", int'(byte_cnt), 8);
        fw_peek("R1 bytes", 8, 1);

        // R3 NAK while setup flag is set
        send_in();
        chk("R3 in", rk, R_NAK);
        send_pkt(K_OUT, 2, 2, 1'b1);
        chk("R3 out", rk, R_NAK);
        chk("R3 out no data", int'(st_rxdata), 0);

        // R12 reply lasts one cycle
        fw_pulse(0);
        send_in();
        chk("R12 data code", rk, R_DATA);
        @(negedge clk);
        chk("R12 single cycle", int'(rsp_vld), 0);

        // R4 no-data status: zero-length DATA1 until acknowledged
        for (int r = 0; r < 2; r++) begin
            send_in();
            chk("R4 kind", rk, R_DATA);
            chk("R4 tgl", rt, 1);
            chk("R4 len", rl, 0);
            chk("R4 not done", int'(st_txdone), 0);
        end
        host_ack();
        chk("R4 strobe", int'(cap_evt), 1);
        chk("R4 done", int'(st_txdone), 1);
        send_in();
        chk("R4 after end", rk, R_NAK);

        // R5 R6 R7 host-to-device sweep over every length
        for (int n = 0; n <= DEPTH; n++) begin
            start_ctl(1'b0);
            send_pkt(K_OUT, n, 20 + n, 1'b1);
            chk("R5 ack", rk, R_ACK);
            chk("R5 strobe", int'(cap_evr), 1);
            chk("R5 flag", int'(st_rxdata), 1);
            chk("R5 count", int'(byte_cnt), n);
            fw_peek("R5 bytes", n, 20 + n);
            send_pkt(K_OUT, 1, 60, 1'b0);
            chk("R5 owned nak", rk, R_NAK);
            fw_pulse(2);
            send_pkt(K_OUT, (n + 3) % 9, 61, 1'b1);
            chk("R6 ack", rk, R_ACK);
            chk("R6 flag", int'(st_rxdata), 0);
            chk("R6 count", int'(byte_cnt), n);
            send_pkt(K_OUT, DEPTH - n, 40 + n, 1'b0);
            chk("R5 second ack", rk, R_ACK);
            chk("R5 second count", int'(byte_cnt), DEPTH - n);
            fw_peek("R5 second bytes", DEPTH - n, 40 + n);
            fw_pulse(2);
            send_in();
            chk("R7 first", rk, R_DATA);
            chk("R7 tgl", rt, 1);
            chk("R7 len", rl, 0);
            send_in();
            chk("R7 retry", rk, R_DATA);
            host_ack();
            chk("R7 done", int'(st_txdone), 1);
        end

        // R8 R9 R10 device-to-host sweep over every length
        for (int n = 0; n <= DEPTH; n++) begin
            start_ctl(1'b1);
            send_in();
            chk("R8 not ready nak", rk, R_NAK);
            for (int i = 0; i < n; i++) fw_write(i, pat(80 + n, i));
            fw_count(n);
            fw_pulse(3);
            fw_write(0, 8'hEE);
            fw_count((n + 1) % 9);
            chk("R10 count kept", int'(byte_cnt), n);
            for (int r = 0; r < 2; r++) begin
                send_in();
                chk("R8 kind", rk, R_DATA);
                chk("R8 tgl", rt, 1);
                chk("R8 len", rl, n);
                for (int i = 0; i < n; i++) begin
                    chk("R8/R10 byte", int'(tx_byte), int'(pat(80 + n, i)));
                    tx_rd = 1'b1;
                    @(negedge clk);
                end
                tx_rd = 1'b0;
            end
            host_ack();
            chk("R8 ready cleared", int'(st_txrdy), 0);
            chk("R8 done", int'(st_txdone), 1);
            if (n == 3) begin
                fw_write(0, 8'h5A);
                fw_count(1);
                fw_pulse(3);
                send_in();
                chk("R8 second tgl", rt, 0);
                chk("R8 second len", rl, 1);
                chk("R8 second byte", int'(tx_byte), 8'h5A);
                host_ack();
            end
            send_pkt(K_OUT, 0, 0, 1'b1);
            chk("R9 held", rk, R_NAK);
            fw_pulse(1);
            send_pkt(K_OUT, 0, 0, 1'b1);
            chk("R9 ack", rk, R_ACK);
            send_in();
            chk("R9 ended", rk, R_NAK);
        end

        // R11 setup overrides a stage in progress
        start_ctl(1'b1);
        fw_count(0);
        fw_pulse(3);
        send_in();
        host_ack();
        fw_pulse(3);
        chk("R11 pre txrdy", int'(st_txrdy), 1);
        chk("R11 pre txdone", int'(st_txdone), 1);
        send_pkt(K_SETUP, 8, 9, 1'b0);
        chk("R11 ack", rk, R_ACK);
        chk("R11 txrdy", int'(st_txrdy), 0);
        chk("R11 txdone", int'(st_txdone), 0);
        start_ctl(1'b0);
        send_pkt(K_OUT, 2, 3, 1'b1);
        chk("R11 pre rxdata", int'(st_rxdata), 1);
        send_pkt(K_SETUP, 8, 9, 1'b0);
        chk("R11 rxdata", int'(st_rxdata), 0);
        fw_pulse(0);
        send_pkt(K_OUT, 2, 4, 1'b1);
        chk("R11 toggle back to 1", int'(st_rxdata), 1);

        finish_run();
    end
endmodule